// File: doc/BRIEF.md
# HDLC Descriptor-Chain Transmit Engine

This block supplies the payload bytes of outgoing bit-oriented synchronous frames to a framer. Software builds a linked list of transmit descriptors in a 16-bit word memory and loads the address of the first descriptor into the engine. Each time the framer asks for a byte, the engine services the request and answers with a single acknowledge. The acknowledge carries either a data byte or one or more command strobes: reset the CRC, append the CRC, abort the frame, or nothing queued. Flag insertion, bit stuffing, CRC arithmetic and the line itself belong to the framer.

A descriptor occupies word offsets from its base address. Offset 0 holds the link to the next descriptor and offset 1 a completion status. Offsets 2 and 3 hold the low and high halves of the buffer address, offset 4 the byte count, and offset 5 the bytes still left. Offsets 8 and 9 are scratch words that hold the running buffer pointer, low half then high half. Each buffer word carries two bytes, and the high byte goes out first.

After the last byte the engine asks for the CRC and parks in an end-of-frame state. The following request marks the descriptor complete, follows the link, and starts the next frame within the same service. A framer underrun aborts the frame. The engine also counts frames, counts underruns, and runs an idle timer that flags a framer that has stopped asking.

Top module: `frame_chain_tx`

## Requirements
- R1: After reset, `tx_state` is 0, `cur_desc` is 0, both statistics counters are 0, no memory request is pending and no acknowledge is given.
- R2: A request while `tx_state` is 0 (ready) and `cur_desc` is 0 is acknowledged with `cmd_idle` alone. `tx_state` stays 0.
- R3: A request in state 0 with a nonzero `cur_desc` starts a frame. The acknowledge carries `cmd_crc_reset`. Descriptor words 2 and 3 are copied to scratch words 8 and 9, and the byte count is loaded from word 4.
- R4: Bytes leave the buffer high half (bits 15:8) first, then low half (bits 7:0). A byte sent from the high half leaves `tx_state` at 2. A byte sent from the low half leaves it at 1, advances the buffer pointer by one word, and rewrites scratch words 8 and 9. The memory address is the low AW bits of that pointer.
- R5: Each data request first decrements the count. When the result would be negative, no byte is sent. The acknowledge carries `cmd_crc_send`, `cur_desc` takes word 0 of the active descriptor, and `tx_state` becomes 3. A count of N therefore yields N bytes, and a count of 0 yields the CRC strobe together with the reset strobe.
- R6: After every data byte, the decremented count is written to descriptor word 5.
- R7: A request in state 3 writes 0xFFFF to word 1 of the finished descriptor and reloads `cur_desc` from its word 0. It also increments `frames_sent`, returns to state 0, and in the same service starts the next frame, or reports idle if the link is 0.
- R8: If bit 6 of `fr_status` is set when a request arrives in state 1 or 2, the acknowledge carries `cmd_abort` alone. `underrun_count` increments, `tx_state` returns to 0, and `cur_desc` is kept, so the same descriptor restarts on the next request.
- R9: Bits of `fr_status` other than bit 6 have no effect on the bytes sent.
- R10: Each `tick` advances an idle timer of TW bits, and every acknowledge clears it. When 2^TW ticks pass without an acknowledge, `idle_timeout` pulses for one cycle.
- R11: The memory port has at most one access outstanding. `mem_req_valid` is held, with address, write enable and write data unchanged, until `mem_req_ready`. A read completes on `mem_rsp_valid`.
- R12: `head_load` sets `cur_desc` to `head_ptr` while no request is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | One-cycle byte request from the framer |
| fr_status | input | 8 | Framer status; bit 6 means underrun |
| tx_ack | output | 1 | One-cycle end of service |
| tx_byte_valid | output | 1 | Acknowledge carries a data byte |
| tx_byte | output | 8 | Data byte |
| cmd_crc_reset | output | 1 | Reset-CRC strobe, valid with tx_ack |
| cmd_crc_send | output | 1 | Append-CRC strobe, valid with tx_ack |
| cmd_abort | output | 1 | Abort-frame strobe, valid with tx_ack |
| cmd_idle | output | 1 | Nothing queued, valid with tx_ack |
| head_load | input | 1 | Load the descriptor pointer |
| head_ptr | input | 16 | Value for head_load |
| cur_desc | output | 16 | Current descriptor pointer |
| tx_state | output | 2 | 0 ready, 1 high byte next, 2 low byte next, 3 end-of-frame |
| frames_sent | output | CW | Completed frame counter |
| underrun_count | output | CW | Underrun counter |
| tick | input | 1 | Idle-timer advance |
| idle_timeout | output | 1 | Idle-timer overflow pulse |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Word address |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Read data |

## Verification
The bench builds the engine with AW=8, CW=8 and TW=4. With AW=8, a buffer whose high address word is nonzero shows that the scratch copy keeps the full pointer while the fetch uses only the low bits. With TW=4, an idle-timer overflow takes sixteen ticks, so the boundary at fifteen and sixteen ticks is reached in a few cycles. The memory model withholds ready in one cycle of every four, which stalls accesses at varying points of a service.

// File: rtl/txc_pkg.sv
package txc_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [1:0] {
    TXS_READY = 2'd0,
    TXS_HIGH  = 2'd1,
    TXS_LOW   = 2'd2,
    TXS_EOF   = 2'd3
  } txs_e;

  // descriptor word offsets
  localparam int unsigned OFF_LINK = 0;
  localparam int unsigned OFF_STAT = 1;
  localparam int unsigned OFF_BUFL = 2;
  localparam int unsigned OFF_BUFH = 3;
  localparam int unsigned OFF_CNT  = 4;
  localparam int unsigned OFF_LEFT = 5;
  localparam int unsigned OFF_PTRL = 8;
  localparam int unsigned OFF_PTRH = 9;

  localparam int unsigned UNDERRUN_BIT = 6;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_RD_LO, PH_WR_LO, PH_RD_HI, PH_WR_HI, PH_RD_CNT,
    PH_DEC, PH_RD_DATA, PH_WR_CNT, PH_WR_PLO, PH_WR_PHI, PH_RD_NEXT,
    PH_WR_STAT, PH_RD_LINK, PH_ACK
  } ph_e;

  function automatic logic [WORD_W-1:0] count_step(input logic [WORD_W-1:0] c);
    return c - 1'b1;
  endfunction

  function automatic logic count_exhausted(input logic [WORD_W-1:0] c);
    logic [WORD_W-1:0] n;
    n = c - 1'b1;
    return n[WORD_W-1];
  endfunction

  function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] w, input logic high);
    return high ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [2*WORD_W-1:0] ptr_next(input logic [2*WORD_W-1:0] p);
    return p + 1'b1;
  endfunction
endpackage

// File: rtl/txc_mem_port.sv
module txc_mem_port #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          m_valid,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic          m_ready,
  input  logic          m_rvalid,
  input  logic [DW-1:0] m_rdata
);
  typedef enum logic [1:0] {MP_IDLE, MP_REQ, MP_RSP} mp_e;
  mp_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= MP_IDLE;
      done    <= 1'b0;
      rdata   <= '0;
      m_valid <= 1'b0;
      m_we    <= 1'b0;
      m_addr  <= '0;
      m_wdata <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        MP_IDLE: if (go) begin
          m_valid <= 1'b1;
          m_we    <= we;
          m_addr  <= addr;
          m_wdata <= wdata;
          st      <= MP_REQ;
        end
        MP_REQ: if (m_ready) begin
          m_valid <= 1'b0;
          if (m_we) begin
            done <= 1'b1;
            st   <= MP_IDLE;
          end else begin
            st <= MP_RSP;
          end
        end
        MP_RSP: if (m_rvalid) begin
          rdata <= m_rdata;
          done  <= 1'b1;
          st    <= MP_IDLE;
        end
        default: st <= MP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txc_idle_timer.sv
module txc_idle_timer #(
  parameter int TW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic timeout
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= !clr && tick && (&cnt);
      if (clr)       cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/txc_stat_ctr.sv
module txc_stat_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (inc) value <= value + 1'b1;
  end
endmodule

// File: rtl/frame_chain_tx.sv
module frame_chain_tx
  import txc_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int TW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_req,
  input  logic [7:0]        fr_status,
  output logic              tx_ack,
  output logic              tx_byte_valid,
  output logic [7:0]        tx_byte,
  output logic              cmd_crc_reset,
  output logic              cmd_crc_send,
  output logic              cmd_abort,
  output logic              cmd_idle,
  input  logic              head_load,
  input  logic [WORD_W-1:0] head_ptr,
  output logic [WORD_W-1:0] cur_desc,
  output logic [1:0]        tx_state,
  output logic [CW-1:0]     frames_sent,
  output logic [CW-1:0]     underrun_count,
  input  logic              tick,
  output logic              idle_timeout,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [AW-1:0]     mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  localparam int PW = 2 * WORD_W;
  localparam int NSTAT = 2;
  localparam int ST_FRAMES = 0;
  localparam int ST_UNDER  = 1;

  function automatic logic [AW-1:0] dword(input logic [WORD_W-1:0] base, input int unsigned off);
    return base[AW-1:0] + AW'(off);
  endfunction

  ph_e               ph;
  txs_e              st;
  logic              pend, waiting;
  logic [WORD_W-1:0] cur, act, cnt;
  logic [PW-1:0]     ptr;
  logic              f_idle, f_rst, f_crc, f_abort, f_byte;
  logic [7:0]        byte_r;

  // access decode
  logic              acc, acc_we, go, mp_done;
  logic [AW-1:0]     acc_addr;
  logic [WORD_W-1:0] acc_wd, mp_rdata;

  // named internal events
  logic ev_dispatch, ev_underrun, ev_frame_done, ev_exhaust;
  logic [NSTAT-1:0] st_inc;
  logic [CW-1:0]    st_val [NSTAT];

  assign ev_dispatch   = (ph == PH_IDLE) && pend;
  assign ev_underrun   = ev_dispatch && (st == TXS_HIGH || st == TXS_LOW) && fr_status[UNDERRUN_BIT];
  assign ev_frame_done = (ph == PH_RD_LINK) && mp_done;
  assign ev_exhaust    = (ph == PH_DEC) && count_exhausted(cnt);

  always_comb begin
    acc      = 1'b1;
    acc_we   = 1'b0;
    acc_addr = '0;
    acc_wd   = '0;
    case (ph)
      PH_RD_LO:   acc_addr = dword(act, OFF_BUFL);
      PH_WR_LO:   begin acc_we = 1'b1; acc_addr = dword(act, OFF_PTRL); acc_wd = ptr[WORD_W-1:0]; end
      PH_RD_HI:   acc_addr = dword(act, OFF_BUFH);
      PH_WR_HI:   begin acc_we = 1'b1; acc_addr = dword(act, OFF_PTRH); acc_wd = ptr[PW-1:WORD_W]; end
      PH_RD_CNT:  acc_addr = dword(act, OFF_CNT);
      PH_RD_DATA: acc_addr = ptr[AW-1:0];
      PH_WR_CNT:  begin acc_we = 1'b1; acc_addr = dword(act, OFF_LEFT); acc_wd = cnt; end
      PH_WR_PLO:  begin acc_we = 1'b1; acc_addr = dword(act, OFF_PTRL); acc_wd = ptr[WORD_W-1:0]; end
      PH_WR_PHI:  begin acc_we = 1'b1; acc_addr = dword(act, OFF_PTRH); acc_wd = ptr[PW-1:WORD_W]; end
      PH_RD_NEXT: acc_addr = dword(act, OFF_LINK);
      PH_WR_STAT: begin acc_we = 1'b1; acc_addr = dword(act, OFF_STAT); acc_wd = '1; end
      PH_RD_LINK: acc_addr = dword(act, OFF_LINK);
      default:    acc = 1'b0;
    endcase
  end

  assign go = acc && !waiting;

  txc_mem_port #(.AW(AW), .DW(WORD_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .go(go), .we(acc_we), .addr(acc_addr), .wdata(acc_wd),
    .done(mp_done), .rdata(mp_rdata),
    .m_valid(mem_req_valid), .m_we(mem_req_we), .m_addr(mem_req_addr), .m_wdata(mem_req_wdata),
    .m_ready(mem_req_ready), .m_rvalid(mem_rsp_valid), .m_rdata(mem_rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; st <= TXS_READY; pend <= 1'b0; waiting <= 1'b0;
      cur <= '0; act <= '0; cnt <= '0; ptr <= '0; byte_r <= '0;
      f_idle <= 1'b0; f_rst <= 1'b0; f_crc <= 1'b0; f_abort <= 1'b0; f_byte <= 1'b0;
    end else begin
      pend <= tx_req | (pend & ~ev_dispatch);
      if (go)           waiting <= 1'b1;
      else if (mp_done) waiting <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (pend) begin
            f_idle <= 1'b0; f_rst <= 1'b0; f_crc <= 1'b0; f_abort <= 1'b0; f_byte <= 1'b0;
            case (st)
              TXS_READY: ph <= PH_START;
              TXS_EOF:   ph <= PH_WR_STAT;
              default: begin
                if (fr_status[UNDERRUN_BIT]) begin
                  f_abort <= 1'b1;
                  st      <= TXS_READY;
                  ph      <= PH_ACK;
                end else begin
                  ph <= PH_DEC;
                end
              end
            endcase
          end else if (head_load) begin
            cur <= head_ptr;
          end
        end
        PH_START: begin
          if (cur == '0) begin
            f_idle <= 1'b1;
            ph     <= PH_ACK;
          end else begin
            f_rst <= 1'b1;
            act   <= cur;
            ph    <= PH_RD_LO;
          end
        end
        PH_RD_LO:  if (mp_done) begin ptr[WORD_W-1:0] <= mp_rdata; ph <= PH_WR_LO; end
        PH_WR_LO:  if (mp_done) ph <= PH_RD_HI;
        PH_RD_HI:  if (mp_done) begin ptr[PW-1:WORD_W] <= mp_rdata; ph <= PH_WR_HI; end
        PH_WR_HI:  if (mp_done) ph <= PH_RD_CNT;
        PH_RD_CNT: if (mp_done) begin cnt <= mp_rdata; st <= TXS_HIGH; ph <= PH_DEC; end
        PH_DEC: begin
          if (ev_exhaust) begin
            f_crc <= 1'b1;
            ph    <= PH_RD_NEXT;
          end else begin
            cnt <= count_step(cnt);
            ph  <= PH_RD_DATA;
          end
        end
        PH_RD_DATA: if (mp_done) begin
          byte_r <= pick_byte(mp_rdata, st == TXS_HIGH);
          f_byte <= 1'b1;
          ph     <= PH_WR_CNT;
        end
        PH_WR_CNT: if (mp_done) begin
          if (st == TXS_LOW) begin
            ptr <= ptr_next(ptr);
            ph  <= PH_WR_PLO;
          end else begin
            st <= TXS_LOW;
            ph <= PH_ACK;
          end
        end
        PH_WR_PLO: if (mp_done) ph <= PH_WR_PHI;
        PH_WR_PHI: if (mp_done) begin st <= TXS_HIGH; ph <= PH_ACK; end
        PH_RD_NEXT: if (mp_done) begin cur <= mp_rdata; st <= TXS_EOF; ph <= PH_ACK; end
        PH_WR_STAT: if (mp_done) ph <= PH_RD_LINK;
        PH_RD_LINK: if (mp_done) begin cur <= mp_rdata; st <= TXS_READY; ph <= PH_START; end
        PH_ACK: ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign st_inc[ST_FRAMES] = ev_frame_done;
  assign st_inc[ST_UNDER]  = ev_underrun;

  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    txc_stat_ctr #(.CW(CW)) u_ctr (.clk(clk), .rst_n(rst_n), .inc(st_inc[g]), .value(st_val[g]));
  end

  assign frames_sent    = st_val[ST_FRAMES];
  assign underrun_count = st_val[ST_UNDER];

  txc_idle_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(tx_ack), .timeout(idle_timeout)
  );

  assign tx_ack        = (ph == PH_ACK);
  assign tx_byte_valid = tx_ack & f_byte;
  assign tx_byte       = byte_r;
  assign cmd_crc_reset = tx_ack & f_rst;
  assign cmd_crc_send  = tx_ack & f_crc;
  assign cmd_abort     = tx_ack & f_abort;
  assign cmd_idle      = tx_ack & f_idle;
  assign cur_desc      = cur;
  assign tx_state      = st;
endmodule

// File: rtl/txc_checker.sv
module txc_checker #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_ack,
  input logic          tx_byte_valid,
  input logic          cmd_crc_send,
  input logic          cmd_abort,
  input logic          cmd_idle,
  input logic [1:0]    tx_state,
  input logic [CW-1:0] frames_sent,
  input logic [CW-1:0] underrun_count,
  input logic          idle_timeout,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [15:0]   mem_req_wdata
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  assert_idle_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack && cmd_idle |-> tx_state == 2'd0 && !tx_byte_valid && !cmd_crc_send);

  assert_byte_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack && tx_byte_valid |-> (tx_state == 2'd1 || tx_state == 2'd2));

  assert_crc_eof_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack && cmd_crc_send |-> tx_state == 2'd3 && !tx_byte_valid);

  assert_frame_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frames_sent != $past(frames_sent) |-> frames_sent == $past(frames_sent) + 1'b1);

  assert_abort_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack && cmd_abort |-> tx_state == 2'd0 && !tx_byte_valid && !cmd_crc_send);

  assert_under_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_count != $past(underrun_count) |-> underrun_count == $past(underrun_count) + 1'b1);

  assert_timeout_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    idle_timeout |=> !idle_timeout);
endmodule

bind frame_chain_tx txc_checker #(.AW(AW), .CW(CW)) i_chk (.*);

// File: tb/test_frame_chain_tx.sv
`timescale 1ns/1ps
module test_frame_chain_tx;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_req = 1'b0;
  logic [7:0] fr_status = 8'h00;
  logic head_load = 1'b0;
  logic [15:0] head_ptr = 16'h0;
  logic tick = 1'b0;
  logic tx_ack, tx_byte_valid, cmd_crc_reset, cmd_crc_send, cmd_abort, cmd_idle;
  logic [7:0] tx_byte;
  logic [15:0] cur_desc;
  logic [1:0] tx_state;
  logic [CW-1:0] frames_sent, underrun_count;
  logic idle_timeout;
  logic mem_req_valid, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [15:0] mem_req_wdata;
  logic mem_req_ready;
  logic mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = 16'h0;

  always #2 clk = ~clk;

  frame_chain_tx #(.AW(AW), .CW(CW), .TW(TW)) i_frame_chain_tx (.*);

  // word memory model, ready withheld one cycle in four
  logic [15:0] mem [256];
  logic [1:0] rdy_q = 2'd0;
  assign mem_req_ready = (rdy_q != 2'd0);
  always @(posedge clk) begin
    rdy_q <= rdy_q + 2'd1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[mem_req_addr] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr];
      end
    end
  end

  int vectors = 0;
  int errors = 0;
  int acks = 0;
  int tmo_cnt = 0;
  logic [12:0] exp_q[$];
  string tag_q[$];

  function automatic logic [12:0] item(input logic idl, input logic rs, input logic cs,
                                       input logic ab, input logic bv, input logic [7:0] b);
    return {idl, rs, cs, ab, bv, bv ? b : 8'h00};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every acknowledge
  always @(negedge clk) begin
    if (rst_n && tx_ack) begin
      logic [12:0] obs;
      obs = item(cmd_idle, cmd_crc_reset, cmd_crc_send, cmd_abort, tx_byte_valid, tx_byte);
      if (exp_q.size() == 0) begin
        vectors++; errors++;
        $display("FAIL unexpected ack actual %0h expected none", obs);
      end else begin
        string t;
        t = tag_q.pop_front();
        check(t, obs, exp_q.pop_front());
      end
      acks++;
    end
    if (idle_timeout) tmo_cnt++;
  end

  // driver: pushes the expectation, issues one request, waits for service
  task automatic serve(input string tag, input logic [7:0] st, input logic [12:0] e);
    int n;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    n = acks + 1;
    @(negedge clk);
    fr_status = st;
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
    while (acks < n) @(negedge clk);
    fr_status = 8'h00;
    @(negedge clk);
  endtask

  task automatic load_head(input logic [15:0] p);
    @(negedge clk);
    head_ptr = p;
    head_load = 1'b1;
    @(negedge clk);
    head_load = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    // descriptor A at 0x10: 3 bytes, buffer 0x0001_0040 (fetches at 0x40)
    mem[8'h10] = 16'h0020; mem[8'h12] = 16'h0040; mem[8'h13] = 16'h0001; mem[8'h14] = 16'd3;
    mem[8'h40] = 16'hA1B2; mem[8'h41] = 16'hC3D4;
    // descriptor B at 0x20: zero length, end of list
    mem[8'h20] = 16'h0000; mem[8'h22] = 16'h0048; mem[8'h24] = 16'd0;
    // descriptor C at 0x30: 4 bytes, buffer 0x50
    mem[8'h30] = 16'h0000; mem[8'h32] = 16'h0050; mem[8'h34] = 16'd4;
    mem[8'h50] = 16'h5566; mem[8'h51] = 16'h7788;

    repeat (3) @(negedge clk);
    check("R1 state", tx_state, 0);
    check("R1 pointer", cur_desc, 0);
    check("R1 frames", frames_sent, 0);
    check("R1 underruns", underrun_count, 0);
    check("R1 mem idle", mem_req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 no ack", tx_ack, 0);

    serve("R2 empty list", 8'h00, item(1, 0, 0, 0, 0, 8'h00));
    check("R2 state", tx_state, 0);

    load_head(16'h0010);
    check("R12 head load", cur_desc, 16'h0010);

    serve("R3 start+first byte", 8'h00, item(0, 1, 0, 0, 1, 8'hA1));
    check("R3 scratch low", mem[8'h18], 16'h0040);
    check("R3 scratch high", mem[8'h19], 16'h0001);
    check("R6 left after 1", mem[8'h15], 2);
    check("R4 state after high", tx_state, 2);
    serve("R4 low byte", 8'h00, item(0, 0, 0, 0, 1, 8'hB2));
    check("R4 pointer advanced", mem[8'h18], 16'h0041);
    check("R4 state after low", tx_state, 1);
    serve("R4 next word high", 8'h00, item(0, 0, 0, 0, 1, 8'hC3));
    check("R6 left after 3", mem[8'h15], 0);
    check("R4 pointer held", mem[8'h18], 16'h0041);
    serve("R5 exhausted", 8'h00, item(0, 0, 1, 0, 0, 8'h00));
    check("R5 state eof", tx_state, 3);
    check("R5 next pointer", cur_desc, 16'h0020);
    check("R7 status untouched yet", mem[8'h11], 0);
    check("R7 frames before", frames_sent, 0);

    serve("R7 complete+start zero length", 8'h00, item(0, 1, 1, 0, 0, 8'h00));
    check("R7 status word", mem[8'h11], 16'hFFFF);
    check("R7 frames", frames_sent, 1);
    check("R5 zero length eof", tx_state, 3);
    check("R7 chained pointer", cur_desc, 0);
    check("R3 scratch of B", mem[8'h28], 16'h0048);
    serve("R7 complete then idle", 8'h00, item(1, 0, 0, 0, 0, 8'h00));
    check("R7 status B", mem[8'h21], 16'hFFFF);
    check("R7 frames 2", frames_sent, 2);
    check("R7 state ready", tx_state, 0);
    check("R11 no request pending", mem_req_valid, 0);

    load_head(16'h0030);
    serve("R3 start C", 8'h00, item(0, 1, 0, 0, 1, 8'h55));
    serve("R9 other status bits", 8'hBF, item(0, 0, 0, 0, 1, 8'h66));
    serve("R8 underrun in high", 8'h40, item(0, 0, 0, 1, 0, 8'h00));
    check("R8 count 1", underrun_count, 1);
    check("R8 state", tx_state, 0);
    check("R8 pointer kept", cur_desc, 16'h0030);
    serve("R8 restart", 8'h00, item(0, 1, 0, 0, 1, 8'h55));
    serve("R8 underrun in low", 8'hFF, item(0, 0, 0, 1, 0, 8'h00));
    check("R8 count 2", underrun_count, 2);
    check("R8 frames unchanged", frames_sent, 2);

    load_head(16'h0000);
    ticks(15);
    check("R10 no timeout at 15", tmo_cnt, 0);
    ticks(1);
    check("R10 timeout at 16", tmo_cnt, 1);
    ticks(10);
    serve("R10 clearing service", 8'h00, item(1, 0, 0, 0, 0, 8'h00));
    ticks(10);
    check("R10 cleared by service", tmo_cnt, 1);
    check("scoreboard drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule